// File: doc/BRIEF.md
# Configurable Registered I/O Macrocell Bank

This block is a bank of programmable-logic I/O cells. Each lane takes terms that a logic array has already formed: a sum term, a polarity term that is XORed with it, a synchronous set term, a synchronous clear term and an output-enable term. From these it produces a pin model (data plus enable) and one feedback bit that goes back to the array. Each lane carries two registers. The state register sits on the output side. The input register samples the external pin value.

Per-lane configuration bits choose six things: where the output enable comes from, whether the pin bypasses the state register, what is fed back, which input clock the input register uses, whether the input register is bypassed, and which state clock drives the state register. The design runs on one fabric clock. The two state clocks and the two input clocks arrive as clock-enable strobes. The configuration inputs are captured only while reset is high and are frozen after that.

Top module: `mc_io_bank`

## Requirements
- R1: While `rst` is high, every state register and every input register clears to 0 at each clock edge. On the first cycle after reset, each lane's `fb_out` and its registered pin data read 0.
- R2: The configuration inputs are loaded on clock edges where `rst` is high. Changes to them while `rst` is low have no effect on any output.
- R3: The state register updates only on an edge where its selected state strobe is high: `sclk1_en` when `cfg_sclk2`=0, `sclk2_en` when `cfg_sclk2`=1. It then loads `sum_term` XOR `xor_term`. On any other edge it holds.
- R4: On an enabled state-clock edge, `set_term`=1 loads 1 and `clr_term`=1 loads 0. When both are 1 the clear wins.
- R5: With `cfg_obyp`=0 the pin data comes from the state register. With `cfg_obyp`=1 it is `sum_term` XOR `xor_term` in the same cycle.
- R6: `pin_oe` equals `oe_term` when `cfg_oe_pin`=0 and the shared `oe_pin` when `cfg_oe_pin`=1. While `pin_oe`=0 the pin is high-impedance and `pin_out` reads 0.
- R7: The input register loads `pin_in` on an edge where its selected input strobe is high: `iclk1_en` when `cfg_iclk2`=0, `iclk2_en` when `cfg_iclk2`=1. On any other edge it holds. It samples whatever the state of `pin_oe`.
- R8: The input path is the input register when `cfg_ibyp`=0 and `pin_in` directly when `cfg_ibyp`=1.
- R9: `fb_out` is the state register when `cfg_fb_in`=0 and the input path when `cfg_fb_in`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset; configuration loads while high |
| sclk1_en | input | 1 | State clock 1 strobe |
| sclk2_en | input | 1 | State clock 2 strobe |
| iclk1_en | input | 1 | Input clock 1 strobe |
| iclk2_en | input | 1 | Input clock 2 strobe |
| oe_pin | input | 1 | Shared output-enable pin |
| cfg_oe_pin | input | LANES | 1: enable from `oe_pin`, 0: from `oe_term` |
| cfg_fb_in | input | LANES | 1: feed back the input path, 0: the state register |
| cfg_iclk2 | input | LANES | 1: input register on strobe 2, 0: on strobe 1 |
| cfg_ibyp | input | LANES | 1: input path bypasses the input register |
| cfg_obyp | input | LANES | 1: pin data bypasses the state register |
| cfg_sclk2 | input | LANES | 1: state register on strobe 2, 0: on strobe 1 |
| sum_term | input | LANES | Sum-of-products data term |
| xor_term | input | LANES | Polarity term XORed with the sum term |
| set_term | input | LANES | Synchronous set term |
| clr_term | input | LANES | Synchronous clear term |
| oe_term | input | LANES | Output-enable term |
| pin_in | input | LANES | External value on the pin |
| pin_out | output | LANES | Pin data (0 while disabled) |
| pin_oe | output | LANES | Pin driver enable |
| fb_out | output | LANES | Feedback bit to the array |

## Verification
The bench targets four failure modes.

- Set and clear arriving on the same enabled edge. A design with the priority inverted would leave the state register at 1.
- Strobes that fire on the unselected clock only. A swapped clock select would update a register that must hold.
- Configuration inputs changed after reset. A design that does not freeze its configuration would switch the output or feedback source in the middle of a run.
- A disabled driver while the pin keeps toggling. The input register must still capture the pin value, and a design that gated sampling on the enable would feed back a stale bit.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef struct packed {
    logic oe_from_pin;
    logic fb_from_input;
    logic in_clk2;
    logic in_bypass;
    logic out_bypass;
    logic st_clk2;
  } cell_cfg_t;
endpackage

// File: rtl/mc_cfg_hold.sv
module mc_cfg_hold
  import mc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  cell_cfg_t [LANES-1:0]   cfg_in,
  output cell_cfg_t [LANES-1:0]   cfg_q
);
  // Configuration is captured only under reset and frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_in;
  end

  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cfg_q));
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg (
  input  logic clk,
  input  logic rst,
  input  logic sclk1_en,
  input  logic sclk2_en,
  input  logic st_clk2,
  input  logic d_term,
  input  logic set_term,
  input  logic clr_term,
  output logic q
);
  logic en;
  assign en = st_clk2 ? sclk2_en : sclk1_en;

  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (en) begin
      if (clr_term)      q <= 1'b0;
      else if (set_term) q <= 1'b1;
      else               q <= d_term;
    end
  end

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (en && clr_term) |=> !q);
  p_set_loads_r4: assert property (@(posedge clk) disable iff (rst)
    (en && set_term && !clr_term) |=> q);
  p_state_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
  p_state_pwrup_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !q);
endmodule

// File: rtl/mc_input_reg.sv
module mc_input_reg (
  input  logic clk,
  input  logic rst,
  input  logic iclk1_en,
  input  logic iclk2_en,
  input  logic in_clk2,
  input  logic pin_in,
  output logic q
);
  logic en;
  assign en = in_clk2 ? iclk2_en : iclk1_en;

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= pin_in;
  end

  p_in_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
  p_in_pwrup_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !q);
endmodule

// File: rtl/mc_io_bank.sv
module mc_io_bank
  import mc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk1_en,
  input  logic             sclk2_en,
  input  logic             iclk1_en,
  input  logic             iclk2_en,
  input  logic             oe_pin,
  input  logic [LANES-1:0] cfg_oe_pin,
  input  logic [LANES-1:0] cfg_fb_in,
  input  logic [LANES-1:0] cfg_iclk2,
  input  logic [LANES-1:0] cfg_ibyp,
  input  logic [LANES-1:0] cfg_obyp,
  input  logic [LANES-1:0] cfg_sclk2,
  input  logic [LANES-1:0] sum_term,
  input  logic [LANES-1:0] xor_term,
  input  logic [LANES-1:0] set_term,
  input  logic [LANES-1:0] clr_term,
  input  logic [LANES-1:0] oe_term,
  input  logic [LANES-1:0] pin_in,
  output logic [LANES-1:0] pin_out,
  output logic [LANES-1:0] pin_oe,
  output logic [LANES-1:0] fb_out
);
  cell_cfg_t [LANES-1:0] cfg_raw;
  cell_cfg_t [LANES-1:0] cfg_q;

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign cfg_raw[g] = '{oe_from_pin:   cfg_oe_pin[g],
                          fb_from_input: cfg_fb_in[g],
                          in_clk2:       cfg_iclk2[g],
                          in_bypass:     cfg_ibyp[g],
                          out_bypass:    cfg_obyp[g],
                          st_clk2:       cfg_sclk2[g]};
  end

  mc_cfg_hold #(.LANES(LANES)) u_cfg (
    .clk(clk), .rst(rst), .cfg_in(cfg_raw), .cfg_q(cfg_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic d_val, st_q, in_q, in_path, drv_val;

    assign d_val = sum_term[g] ^ xor_term[g];

    mc_state_reg u_st (
      .clk(clk), .rst(rst), .sclk1_en(sclk1_en), .sclk2_en(sclk2_en),
      .st_clk2(cfg_q[g].st_clk2), .d_term(d_val),
      .set_term(set_term[g]), .clr_term(clr_term[g]), .q(st_q)
    );

    mc_input_reg u_in (
      .clk(clk), .rst(rst), .iclk1_en(iclk1_en), .iclk2_en(iclk2_en),
      .in_clk2(cfg_q[g].in_clk2), .pin_in(pin_in[g]), .q(in_q)
    );

    assign in_path    = cfg_q[g].in_bypass ? pin_in[g] : in_q;
    assign drv_val    = cfg_q[g].out_bypass ? d_val : st_q;
    assign pin_oe[g]  = cfg_q[g].oe_from_pin ? oe_pin : oe_term[g];
    assign pin_out[g] = pin_oe[g] & drv_val;
    assign fb_out[g]  = cfg_q[g].fb_from_input ? in_path : st_q;

    p_oe_source_r6: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[g].oe_from_pin && !oe_pin) |-> !pin_oe[g]);
    p_quiet_pin_r6: assert property (@(posedge clk) disable iff (rst)
      !pin_oe[g] |-> !pin_out[g]);
    p_fb_state_r9: assert property (@(posedge clk) disable iff (rst)
      (!cfg_q[g].fb_from_input) |-> (fb_out[g] == st_q));
  end
endmodule

// File: tb/test_mc_io_bank.sv
module test_mc_io_bank;
  localparam int L = 4;
  logic clk = 1'b0;
  logic rst, sclk1_en, sclk2_en, iclk1_en, iclk2_en, oe_pin;
  logic [L-1:0] cfg_oe_pin, cfg_fb_in, cfg_iclk2, cfg_ibyp, cfg_obyp, cfg_sclk2;
  logic [L-1:0] sum_term, xor_term, set_term, clr_term, oe_term, pin_in;
  logic [L-1:0] pin_out, pin_oe, fb_out;

  logic [L-1:0] m_oep, m_fbi, m_ic2, m_ibyp, m_obyp, m_sc2, m_sq, m_iq;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mc_io_bank #(.LANES(L)) i_mc_io_bank (.*);

  function automatic logic [L-1:0] exp_oe();
    return (m_oep & {L{oe_pin}}) | (~m_oep & oe_term);
  endfunction
  function automatic logic [L-1:0] exp_pout();
    logic [L-1:0] src = (m_obyp & (sum_term ^ xor_term)) | (~m_obyp & m_sq);
    return src & exp_oe();
  endfunction
  function automatic logic [L-1:0] exp_fb();
    logic [L-1:0] ip = (m_ibyp & pin_in) | (~m_ibyp & m_iq);
    return (m_fbi & ip) | (~m_fbi & m_sq);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [L-1:0] act, input logic [L-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_sq = '0; m_iq = '0;
      m_oep = cfg_oe_pin; m_fbi = cfg_fb_in; m_ic2 = cfg_iclk2;
      m_ibyp = cfg_ibyp; m_obyp = cfg_obyp; m_sc2 = cfg_sclk2;
    end else begin
      for (int i = 0; i < L; i++) begin
        logic se = m_sc2[i] ? sclk2_en : sclk1_en;
        logic ie = m_ic2[i] ? iclk2_en : iclk1_en;
        if (se) m_sq[i] = clr_term[i] ? 1'b0 : (set_term[i] ? 1'b1 : sum_term[i] ^ xor_term[i]);
        if (ie) m_iq[i] = pin_in[i];
      end
    end
  endtask

  // Inputs are driven at the falling edge; outputs compared just after.
  task automatic step(input string tag, input bit check);
    #1;
    if (check) begin
      chk(tag, "pin_oe", pin_oe, exp_oe());
      chk(tag, "pin_out", pin_out, exp_pout());
      chk(tag, "fb_out", fb_out, exp_fb());
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic quiet();
    sclk1_en = 0; sclk2_en = 0; iclk1_en = 0; iclk2_en = 0; oe_pin = 0;
    sum_term = '0; xor_term = '0; set_term = '0; clr_term = '0;
    oe_term = '0; pin_in = '0;
  endtask

  task automatic do_reset(input logic [L-1:0] oep, fbi, ic2, ibyp, obyp, sc2);
    cfg_oe_pin = oep; cfg_fb_in = fbi; cfg_iclk2 = ic2;
    cfg_ibyp = ibyp; cfg_obyp = obyp; cfg_sclk2 = sc2;
    rst = 1; step("R1", 0); step("R1", 0); rst = 0;
  endtask

  task automatic randomize_inputs();
    logic [31:0] r = $urandom;
    sclk1_en = r[0]; sclk2_en = r[1]; iclk1_en = r[2]; iclk2_en = r[3]; oe_pin = r[4];
    sum_term = L'($urandom); xor_term = L'($urandom); set_term = L'($urandom);
    clr_term = L'($urandom); oe_term = L'($urandom); pin_in = L'($urandom);
    cfg_oe_pin = L'($urandom); cfg_fb_in = L'($urandom); cfg_iclk2 = L'($urandom);
    cfg_ibyp = L'($urandom); cfg_obyp = L'($urandom); cfg_sclk2 = L'($urandom);
  endtask

  initial begin
    #800000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; quiet();
    {cfg_oe_pin, cfg_fb_in, cfg_iclk2, cfg_ibyp, cfg_obyp, cfg_sclk2} = '0;
    @(negedge clk);

    // R1: both registers cleared; state register feedback and registered pin are 0.
    do_reset({L{1'b1}}, 4'b1010, '0, '0, '0, '0);
    oe_pin = 1; pin_in = '1;
    #1; chk("R1", "pin_out", pin_out, '0); chk("R1", "fb_out", fb_out, '0);
    step("R1", 1);

    // R3: strobe on the unselected state clock does not update; selected one does.
    quiet(); do_reset('1, '0, '0, '0, '0, 4'b0011); oe_pin = 1;
    sum_term = '1; sclk1_en = 1; step("R3", 1);
    sclk1_en = 0; step("R3", 1);
    #1; chk("R3", "fb_out", fb_out, 4'b1100);
    sclk2_en = 1; sum_term = '1; xor_term = 4'b0001; step("R3", 1);
    sclk2_en = 0; #1; chk("R3", "fb_out", fb_out, 4'b1110); step("R3", 1);

    // R4: set and clear together; clear wins.
    quiet(); do_reset('1, '0, '0, '0, '0, '0); oe_pin = 1;
    sclk1_en = 1; set_term = '1; step("R4", 1);
    #1; chk("R4", "fb_out", fb_out, '1);
    clr_term = 4'b0101; step("R4", 1);
    #1; chk("R4", "fb_out", fb_out, 4'b1010); step("R4", 1);

    // R5: bypass lanes follow sum^xor at once, registered lanes lag an edge.
    quiet(); do_reset('1, '0, '0, '0, 4'b0011, '0); oe_pin = 1;
    sum_term = 4'b0110; xor_term = 4'b0011;
    #1; chk("R5", "pin_out", pin_out, 4'b0001); step("R5", 1);
    sclk1_en = 1; step("R5", 1); step("R5", 1);

    // R6: product-term vs shared enable; disabled lanes read 0.
    quiet(); do_reset(4'b1100, '0, '0, '0, '1, '0);
    sum_term = '1; oe_term = 4'b0101; oe_pin = 0;
    #1; chk("R6", "pin_oe", pin_oe, 4'b0001); chk("R6", "pin_out", pin_out, 4'b0001);
    step("R6", 1); oe_pin = 1; step("R6", 1);

    // R7: input register samples with the driver off, on its selected strobe only.
    quiet(); do_reset('0, '1, 4'b1100, '0, '0, '0);
    pin_in = 4'b1111; iclk1_en = 1; step("R7", 1);
    iclk1_en = 0; pin_in = '0; #1; chk("R7", "fb_out", fb_out, 4'b0011);
    iclk2_en = 1; pin_in = '1; step("R7", 1);
    iclk2_en = 0; pin_in = '0; #1; chk("R7", "fb_out", fb_out, 4'b1111); step("R7", 1);

    // R8 / R9: bypassed input path is the pin itself; feedback source per lane.
    quiet(); do_reset('0, 4'b0111, '0, 4'b0011, '0, '0);
    pin_in = 4'b1111;
    #1; chk("R8", "fb_out", fb_out, 4'b0011); chk("R9", "fb_out", fb_out, 4'b0011);
    step("R8", 1); step("R9", 1);

    // R2: configuration changes without reset are ignored.
    cfg_fb_in = '0; cfg_ibyp = '1; cfg_oe_pin = '1; oe_term = '1; oe_pin = 0;
    #1; chk("R2", "fb_out", fb_out, 4'b0011); chk("R2", "pin_oe", pin_oe, '1);
    step("R2", 1);

    // Random sweep over configurations.
    for (int k = 0; k < 10; k++) begin
      quiet();
      do_reset(L'($urandom), L'($urandom), L'($urandom), L'($urandom), L'($urandom), L'($urandom));
      for (int c = 0; c < 150; c++) begin
        randomize_inputs();
        step("R2", 1);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule